// File: doc/BRIEF.md
# Dendritic Compartment Join Tree

This block merges the accumulated synaptic inputs of the four dendritic compartments of one neuron into a single value that drives the soma. Compartment 0 is the root. Each of compartments 1, 2 and 3 names a parent compartment and a join operator. The child's value is folded into its parent's value with that operator. The available joins are a saturating sum, a largest-magnitude pick, a bitwise OR and a pass-through that drops the child. The fold runs from the highest-numbered compartment down to compartment 1. Every child is therefore complete before it is merged into its parent, and the root holds the fully joined value.

All four inputs are presented together with `in_valid`. The combinational fold result of the root is captured in an output register on the next clock edge, so the soma input is valid one cycle later. A two-state output machine tracks whether the register holds a fresh result. In `ST_IDLE` no fresh result is present. In `ST_VALID` the value captured at the last edge is fresh. The transitions are named as follows:
- `T_CAPTURE` (IDLE to VALID) fires when `in_valid` is high.
- `T_STREAM` (VALID to VALID) fires when `in_valid` stays high.
- `T_DRAIN` (VALID to IDLE) fires when `in_valid` is low.
- `T_REST` (IDLE to IDLE) fires when `in_valid` stays low.

Top module: `dj_join_tree`

## Requirements
- R1: When `in_valid` is sampled high at a rising edge, `out_valid` is high and `soma_out` holds the joined root value after that same edge. Before that edge, `soma_out` keeps its previous value.
- R2: Join code 00 (ADD) replaces the parent with parent + child, saturated to the 24-bit signed range [-8388608, 8388607].
- R3: Join code 01 (ABS_MAX) replaces the parent with whichever operand has the larger magnitude, sign included. On equal magnitudes the parent is kept. The value -8388608 has magnitude 8388608.
- R4: Join code 10 (OR) replaces the parent with the bitwise OR of the two 24-bit operands.
- R5: Join code 11 (PASS) leaves the parent unchanged, and the child's value has no effect on the result.
- R6: For compartment k (1..3), the parent index is `cfg_parent[2k-1:2k-2]` and the join code is `cfg_op[2k-1:2k-2]`. Compartment k's input is `comp_in[24k+23:24k]`. A parent index that is not below k is treated as 0 (the root).
- R7: The joins are applied in the order compartment 3, then 2, then 1. Each uses the value its parent holds at that point in the fold.
- R8: After reset, `out_valid` is 0 and `soma_out` is 0. When `in_valid` is sampled low, `out_valid` is 0 after the edge and `soma_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Compartment inputs and configuration are valid |
| comp_in | input | 96 | Four 24-bit signed compartment inputs, compartment 0 in the low bits |
| cfg_parent | input | 6 | 2-bit parent index for each of compartments 1..3 |
| cfg_op | input | 6 | 2-bit join code for each of compartments 1..3 |
| out_valid | output | 1 | `soma_out` holds a result captured at the last edge |
| soma_out | output | 24 | Joined root value driving the soma, signed |

## Verification
The assertions check several properties on every cycle:
- A high `in_valid` sets `out_valid` one cycle later.
- The output register captures the fold result of that cycle.
- A low `in_valid` clears `out_valid` and freezes `soma_out`.
- Inside each join stage, a sum of same-signed operands never wraps, and a largest-magnitude pick always returns one of its two operands.

Some behaviour is visible only in the bench's directed scenarios: exact saturation limits, tie handling, the fallback for an illegal parent index, and the effect of the descending fold order on branching and chained trees. Those scenarios compare the results with values worked out by hand.

// File: rtl/dj_pkg.sv
package dj_pkg;
    localparam int DJ_W = 24;
    localparam int DJ_N = 4;

    typedef enum logic [1:0] {
        JOIN_ADD    = 2'b00,
        JOIN_ABSMAX = 2'b01,
        JOIN_OR     = 2'b10,
        JOIN_PASS   = 2'b11
    } join_op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_VALID = 1'b1
    } out_state_e;
endpackage

// File: rtl/dj_join_unit.sv
module dj_join_unit
    import dj_pkg::*;
#(
    parameter int W = DJ_W
) (
    input  join_op_e             op,
    input  logic signed [W-1:0]  parent,
    input  logic signed [W-1:0]  child,
    output logic signed [W-1:0]  result
);
    localparam logic signed [W:0] SMAX = {2'b00, {(W-1){1'b1}}};
    localparam logic signed [W:0] SMIN = {2'b11, {(W-1){1'b0}}};

    logic signed [W:0] wide_sum;
    logic signed [W:0] par_ext, chd_ext;
    logic        [W:0] par_mag, chd_mag;

    always_comb begin
        par_ext  = {parent[W-1], parent};
        chd_ext  = {child[W-1], child};
        wide_sum = par_ext + chd_ext;
        par_mag  = parent[W-1] ? W'(0) - par_ext : par_ext;
        chd_mag  = child[W-1]  ? W'(0) - chd_ext : chd_ext;
        unique case (op)
            JOIN_ADD: begin
                if (wide_sum > SMAX)      result = SMAX[W-1:0];
                else if (wide_sum < SMIN) result = SMIN[W-1:0];
                else                      result = wide_sum[W-1:0];
            end
            JOIN_ABSMAX: result = (chd_mag > par_mag) ? child : parent;
            JOIN_OR:     result = parent | child;
            default:     result = parent;
        endcase
    end

    always_comb begin
        if (!$isunknown({op, parent, child, result})) begin
            if (op == JOIN_ADD && !parent[W-1] && !child[W-1])
                a_r2_add_no_wrap_pos: assert (!result[W-1]);
            if (op == JOIN_ADD && parent[W-1] && child[W-1])
                a_r2_add_no_wrap_neg: assert (result[W-1]);
            if (op == JOIN_ABSMAX)
                a_r3_absmax_operand: assert (result == parent || result == child);
        end
    end
endmodule

// File: rtl/dj_fold_tree.sv
module dj_fold_tree
    import dj_pkg::*;
#(
    parameter int W = DJ_W,
    parameter int N = DJ_N
) (
    input  logic [N*W-1:0]                 comp_in,
    input  logic [(N-1)*$clog2(N)-1:0]     cfg_parent,
    input  logic [(N-1)*2-1:0]             cfg_op,
    output logic signed [W-1:0]            root
);
    localparam int IW = $clog2(N);

    logic [N*W-1:0] stage [0:N-1];

    assign stage[0] = comp_in;

    for (genvar j = 0; j < N - 1; j++) begin : g_stage
        localparam int K = N - 1 - j;   // R7: compartment folded at this stage
        logic [IW-1:0]        raw_par;
        logic [IW-1:0]        pidx;
        join_op_e             op;
        logic signed [W-1:0]  par_val;
        logic signed [W-1:0]  chd_val;
        logic signed [W-1:0]  jres;

        assign raw_par = cfg_parent[(K-1)*IW +: IW];
        assign pidx    = (int'(raw_par) < K) ? raw_par : IW'(0);   // R6 fallback
        assign op      = join_op_e'(cfg_op[(K-1)*2 +: 2]);
        assign par_val = stage[j][int'(pidx)*W +: W];
        assign chd_val = stage[j][K*W +: W];

        dj_join_unit #(.W(W)) u_join (
            .op     (op),
            .parent (par_val),
            .child  (chd_val),
            .result (jres)
        );

        for (genvar i = 0; i < N; i++) begin : g_slot
            assign stage[j+1][i*W +: W] = (int'(pidx) == i) ? jres : stage[j][i*W +: W];
        end
    end

    assign root = stage[N-1][W-1:0];
endmodule

// File: rtl/dj_join_tree.sv
module dj_join_tree
    import dj_pkg::*;
#(
    parameter int W = DJ_W,
    parameter int N = DJ_N
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [N*W-1:0]              comp_in,
    input  logic [(N-1)*$clog2(N)-1:0]  cfg_parent,
    input  logic [(N-1)*2-1:0]          cfg_op,
    output logic                        out_valid,
    output logic signed [W-1:0]         soma_out
);
    out_state_e          state_q, state_d;
    logic signed [W-1:0] root_w;

    dj_fold_tree #(.W(W), .N(N)) u_fold (
        .comp_in    (comp_in),
        .cfg_parent (cfg_parent),
        .cfg_op     (cfg_op),
        .root       (root_w)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = in_valid ? ST_VALID : ST_IDLE;   // T_CAPTURE / T_REST
            ST_VALID: state_d = in_valid ? ST_VALID : ST_IDLE;   // T_STREAM / T_DRAIN
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        soma_out <= '0;
        else if (in_valid) soma_out <= root_w;
    end

    assign out_valid = (state_q == ST_VALID);

    a_r1_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_capture_root: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> soma_out == $past(root_w));
    a_r8_drop_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r8_hold_value: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(soma_out));
endmodule

// File: tb/dj_join_tree_bench.sv
module dj_join_tree_bench;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [95:0]        comp_in = '0;
    logic [5:0]         cfg_parent = '0;
    logic [5:0]         cfg_op = '0;
    logic               out_valid;
    logic signed [23:0] soma_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    dj_join_tree u_dj_join_tree (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .comp_in    (comp_in),
        .cfg_parent (cfg_parent),
        .cfg_op     (cfg_op),
        .out_valid  (out_valid),
        .soma_out   (soma_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Present one input set; check latency and the joined result.
    task automatic run(input int c0, input int c1, input int c2, input int c3,
                       input logic [5:0] par, input logic [5:0] op,
                       input int exp, input string req);
        int prev;
        @(negedge clk);
        prev       = int'(soma_out);
        comp_in    = {24'(c3), 24'(c2), 24'(c1), 24'(c0)};
        cfg_parent = par;
        cfg_op     = op;
        in_valid   = 1'b1;
        #1;
        check(int'(soma_out) == prev, "R1 unchanged before edge", int'(soma_out), prev);
        @(posedge clk);
        #1;
        check(out_valid == 1'b1, "R1 out_valid", int'(out_valid), 1);
        check(int'(soma_out) == exp, req, int'(soma_out), exp);
    endtask

    task automatic t_reset();
        check(out_valid == 1'b0, "R8 reset out_valid", int'(out_valid), 0);
        check(int'(soma_out) == 0, "R8 reset soma_out", int'(soma_out), 0);
    endtask

    task automatic t_add();
        run(100, 200, 300, 400, 6'b000000, 6'b000000, 1000, "R2 add all to root");
        run(8000000, 8000000, 0, 0, 6'b000000, 6'b111100, 8388607, "R2 positive saturation");
        run(-8000000, -8000000, 0, 0, 6'b000000, 6'b111100, -8388608, "R2 negative saturation");
        run(-8388608, -1, 0, 0, 6'b000000, 6'b111100, -8388608, "R2 minimum stays");
    endtask

    task automatic t_absmax();
        run(-50, 40, 0, 0, 6'b000000, 6'b111101, -50, "R3 parent larger");
        run(30, -70, 0, 0, 6'b000000, 6'b111101, -70, "R3 child larger keeps sign");
        run(25, -25, 0, 0, 6'b000000, 6'b111101, 25, "R3 tie keeps parent");
        run(8388607, -8388608, 0, 0, 6'b000000, 6'b111101, -8388608, "R3 most negative magnitude");
    endtask

    task automatic t_or();
        run('h0F0, 'h00F, 'h100, 'h7777, 6'b000000, 6'b111010, 'h1FF, "R4 bitwise or");
    endtask

    task automatic t_pass();
        run(7, 1000, -3, 9, 6'b000000, 6'b111111, 7, "R5 pass ignores children");
        run(7, -5000, 12, -9, 6'b000000, 6'b111111, 7, "R5 child change ignored");
    endtask

    task automatic t_parent();
        run(1, 40, 50, 2, 6'b110000, 6'b001111, 3, "R6 self parent falls to root");
        run(10, 5, 900, 0, 6'b000010, 6'b111100, 15, "R6 forward parent falls to root");
    endtask

    task automatic t_order();
        // chain 3->2->1->0: c2=60-100=-40; absmax(50,-40)=50; 10+50
        run(10, 50, 60, -100, 6'b100100, 6'b000100, 60, "R7 chain order");
        // branch 3,2 -> 1: absmax(3,-6)=-6; -6+4=-2; -2 | 16 = -2
        run(16, 3, 4, -6, 6'b010100, 6'b010010, -2, "R7 descending order on branch");
    endtask

    task automatic t_hold();
        @(negedge clk);
        in_valid = 1'b0;
        comp_in  = {24'd5, 24'd6, 24'd7, 24'd8};
        cfg_op   = 6'b000000;
        @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R8 valid drops", int'(out_valid), 0);
        check(int'(soma_out) == -2, "R8 value held", int'(soma_out), -2);
        @(posedge clk);
        #1;
        check(int'(soma_out) == -2, "R8 value still held", int'(soma_out), -2);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_add();
        t_absmax();
        t_or();
        t_pass();
        t_parent();
        t_order();
        t_hold();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule